// File: doc/BRIEF.md
# Root Port Wake-Event Controller

This block holds the status and change state of a single host-controller root port and turns port events into an interrupt request and a power-management wake request. Hardware detection logic elsewhere delivers one-cycle strobes for a resume K-state, a device connect, a device disconnect and an over-current condition. A small software write port updates the port control bits and the three per-event wake enables. The same port also sets the interrupt enable and acknowledges the shared port-change status.

Every event that takes effect sets the shared port-change status flag. The interrupt request follows that flag, gated only by the global interrupt enable. The wake request is gated per event type and stays latched until software acknowledges the change. Software ends a resume by writing zero to the force-resume bit. If the controller is halted at that moment, the port falls back into suspend and a re-suspend flag is raised.

All state is registered. An event or write sampled at a rising edge is visible on the outputs right after that edge. The status and request pins are plain level outputs with no handshake.

Top module: `usb_port_wake_ctl`

## Requirements
- R1: After reset every status flag, every enable, `irq_req` and `pme_req` are 0.
- R2: A resume pulse on a suspended port sets force-resume and port-change status and requests wake with no enable needed. On a port that is not suspended the pulse changes nothing.
- R3: A write with select 0 is a port-control write. In it, data bit 2 = 0 while force-resume is 1 and `ctl_halted` = 0 clears force-resume and suspend and leaves the port enabled.
- R4: The same write while `ctl_halted` = 1 clears force-resume, keeps suspend at 1 and sets `port_resuspend`. That flag clears on the next resume pulse that takes effect, or when the port loses enable.
- R5: A disconnect on a connected port clears connect, enable, suspend and force-resume and sets connect-change and port-change status. A disconnect on an unconnected port changes nothing.
- R6: A connect on an unconnected port sets connect, connect-change and port-change status and clears over-current-active. A connect on a connected port changes nothing.
- R7: An over-current pulse on a connected port sets over-current-active, over-current-change and port-change status, and it clears enable and suspend.
- R8: `irq_req` is 1 exactly when port-change status is 1 and the interrupt enable is 1. The interrupt enable is data bit 0 of a write with select 2.
- R9: Writes with select 1 set the wake enables: bit 0 for connect, bit 1 for disconnect, bit 2 for over-current. A connect, disconnect or over-current that takes effect raises `pme_req` only if its own enable is 1. `pme_req` then holds until port-change status is acknowledged, and it is never 1 while port-change status is 0.
- R10: Data bit 0 = 1 in a write with select 3 clears port-change status and `pme_req`. A 0 in that bit has no effect.
- R11: In a port-control write, bit 3 = 1 clears connect-change and bit 4 = 1 clears over-current-change. A 0 in either bit has no effect on that flag.
- R12: When an event that sets port-change status, connect-change or over-current-change comes in the same cycle as the software clear of that flag, the flag ends up set.
- R13: Port-control bit 0 sets enable only when the port is connected and over-current-active is 0, and a 0 in bit 0 clears enable. Bit 1 = 1 sets suspend only on a port that is already enabled. Suspend is never 1 without enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_resume_k | input | 1 | Resume K-state strobe |
| ev_connect | input | 1 | Device connect strobe |
| ev_disconnect | input | 1 | Device disconnect strobe |
| ev_overcurrent | input | 1 | Over-current strobe |
| ctl_halted | input | 1 | Controller halted level |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_sel | input | 2 | Write select: 0 port control, 1 wake enables, 2 interrupt enable, 3 status acknowledge |
| sw_wr_data | input | 5 | Write data |
| port_connected | output | 1 | Connect status |
| port_enabled | output | 1 | Enable status |
| port_suspended | output | 1 | Suspend status |
| port_force_resume | output | 1 | Force-resume status |
| port_conn_change | output | 1 | Connect-change flag |
| port_oc_active | output | 1 | Over-current-active flag |
| port_oc_change | output | 1 | Over-current-change flag |
| port_resuspend | output | 1 | Port fell back to suspend after a halted resume end |
| port_change_sts | output | 1 | Shared port-change status |
| irq_req | output | 1 | Interrupt request |
| pme_req | output | 1 | Wake request |

## Verification
The properties assume that each event input is a one-cycle strobe and that a write lasts one cycle. Their antecedents exclude the other events that could override the checked effect in the same cycle, such as a disconnect racing a resume. The bench drives every strobe and every write for exactly one clock, from the falling edge to the next falling edge. It only combines an event with a write on purpose, in the collision scenario. The controller-halted level changes only between writes.

// File: rtl/pws_pkg.sv
package pws_pkg;

  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_PORT = 2'd0,
    SEL_WAKE = 2'd1,
    SEL_IEN  = 2'd2,
    SEL_STAT = 2'd3
  } pws_sel_e;

  // port-control field positions
  localparam int PB_EN   = 0;
  localparam int PB_SUSP = 1;
  localparam int PB_FPR  = 2;
  localparam int PB_CSC  = 3;
  localparam int PB_OCC  = 4;
  localparam int PORT_W  = 5;

  // wake-enable field positions
  localparam int WB_CONN = 0;
  localparam int WB_DISC = 1;
  localparam int WB_OC   = 2;
  localparam int WAKE_W  = 3;

  localparam int IB_PCE  = 0;
  localparam int SB_PCI  = 0;

  typedef struct packed {
    logic en_wr;
    logic en_val;
    logic susp_set;
    logic fpr_zero;
    logic csc_w1c;
    logic occ_w1c;
  } pws_pcmd_t;

  typedef struct packed {
    logic              wake_wr;
    logic [WAKE_W-1:0] wake_val;
    logic              ien_wr;
    logic              ien_val;
    logic              pci_w1c;
  } pws_ncmd_t;

  typedef struct packed {
    logic resume;
    logic conn;
    logic disc;
    logic oc;
  } pws_hit_t;

endpackage

// File: rtl/pws_sw_decode.sv
module pws_sw_decode
  import pws_pkg::*;
#(
  parameter int DATA_W = 5
) (
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output pws_pcmd_t         pcmd,
  output pws_ncmd_t         ncmd
);

  pws_sel_e sel;
  assign sel = pws_sel_e'(wr_sel);

  always_comb begin
    pcmd = '0;
    ncmd = '0;
    if (wr_en) begin
      unique case (sel)
        SEL_PORT: begin
          pcmd.en_wr    = 1'b1;
          pcmd.en_val   = wr_data[PB_EN];
          pcmd.susp_set = wr_data[PB_SUSP];
          pcmd.fpr_zero = ~wr_data[PB_FPR];
          pcmd.csc_w1c  = wr_data[PB_CSC];
          pcmd.occ_w1c  = wr_data[PB_OCC];
        end
        SEL_WAKE: begin
          ncmd.wake_wr  = 1'b1;
          ncmd.wake_val = wr_data[WAKE_W-1:0];
        end
        SEL_IEN: begin
          ncmd.ien_wr  = 1'b1;
          ncmd.ien_val = wr_data[IB_PCE];
        end
        SEL_STAT: begin
          ncmd.pci_w1c = wr_data[SB_PCI];
        end
        default: begin
          pcmd = '0;
          ncmd = '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/pws_port_state.sv
module pws_port_state
  import pws_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ev_resume,
  input  logic      ev_conn,
  input  logic      ev_disc,
  input  logic      ev_oc,
  input  logic      halted,
  input  pws_pcmd_t cmd,
  output logic      conn,
  output logic      en,
  output logic      susp,
  output logic      fpr,
  output logic      csc,
  output logic      oca,
  output logic      occ,
  output logic      resusp,
  output pws_hit_t  hit
);

  logic conn_n, en_n, susp_n, fpr_n, csc_n, oca_n, occ_n, resusp_n;
  logic fpr_term;

  always_comb begin
    hit.disc   = ev_disc & conn;
    hit.conn   = ev_conn & ~conn;
    hit.oc     = ev_oc & conn;
    hit.resume = ev_resume & susp & ~hit.disc & ~hit.oc;
  end

  assign fpr_term = cmd.fpr_zero & fpr;

  always_comb begin
    conn_n   = conn;
    en_n     = en;
    susp_n   = susp;
    fpr_n    = fpr;
    csc_n    = csc;
    oca_n    = oca;
    occ_n    = occ;
    resusp_n = resusp;

    if (hit.conn) begin
      conn_n = 1'b1;
      oca_n  = 1'b0;
    end
    if (hit.disc) conn_n = 1'b0;

    if (cmd.en_wr) en_n = cmd.en_val & conn & ~oca;
    if (hit.oc || hit.disc) en_n = 1'b0;

    if (cmd.susp_set && en) susp_n = 1'b1;
    if (fpr_term && !halted && !hit.resume) susp_n = 1'b0;

    if (hit.resume)    fpr_n = 1'b1;
    else if (fpr_term) fpr_n = 1'b0;

    if (cmd.csc_w1c) csc_n = 1'b0;
    if (hit.conn || hit.disc) csc_n = 1'b1;

    if (hit.oc) oca_n = 1'b1;

    if (cmd.occ_w1c) occ_n = 1'b0;
    if (hit.oc) occ_n = 1'b1;

    if (!en_n) begin
      susp_n = 1'b0;
      fpr_n  = 1'b0;
    end

    if (hit.resume || !en_n) resusp_n = 1'b0;
    else if (fpr_term && halted) resusp_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conn   <= 1'b0;
      en     <= 1'b0;
      susp   <= 1'b0;
      fpr    <= 1'b0;
      csc    <= 1'b0;
      oca    <= 1'b0;
      occ    <= 1'b0;
      resusp <= 1'b0;
    end else begin
      conn   <= conn_n;
      en     <= en_n;
      susp   <= susp_n;
      fpr    <= fpr_n;
      csc    <= csc_n;
      oca    <= oca_n;
      occ    <= occ_n;
      resusp <= resusp_n;
    end
  end

  AST_RESUME_SETS_FPR: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_resume && susp && !ev_disc && !ev_oc && !(cmd.en_wr && !cmd.en_val)) |=> fpr); // R2
  AST_RESUME_END: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.fpr_zero && fpr && !halted && !ev_resume && !ev_disc && !ev_oc) |=> (!fpr && !susp)); // R3
  AST_RESUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.fpr_zero && fpr && halted && !ev_resume && !ev_disc && !ev_oc && !(cmd.en_wr && !cmd.en_val))
      |=> (susp && resusp && !fpr)); // R4
  AST_DISC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_disc && conn) |=> (!conn && !en && !susp && csc)); // R5
  AST_CONN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_conn && !conn) |=> (conn && csc)); // R6
  AST_OC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_oc && conn) |=> (oca && occ && !en)); // R7
  AST_SUSP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    susp |-> en); // R13

endmodule

// File: rtl/pws_notify.sv
module pws_notify
  import pws_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pws_hit_t  hit,
  input  pws_ncmd_t cmd,
  output logic      pci,
  output logic      irq,
  output logic      pme
);

  logic [WAKE_W-1:0] wake_en;
  logic              ien;
  logic              any_hit;
  logic              pme_set;

  assign any_hit = hit.resume | hit.conn | hit.disc | hit.oc;
  assign pme_set = hit.resume
                 | (hit.conn & wake_en[WB_CONN])
                 | (hit.disc & wake_en[WB_DISC])
                 | (hit.oc   & wake_en[WB_OC]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_en <= '0;
      ien     <= 1'b0;
      pci     <= 1'b0;
      pme     <= 1'b0;
    end else begin
      if (cmd.wake_wr) wake_en <= cmd.wake_val;
      if (cmd.ien_wr)  ien     <= cmd.ien_val;
      if (any_hit)          pci <= 1'b1;
      else if (cmd.pci_w1c) pci <= 1'b0;
      if (pme_set)          pme <= 1'b1;
      else if (cmd.pci_w1c) pme <= 1'b0;
    end
  end

  assign irq = pci & ien;

  AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |=> pci); // R12
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.pci_w1c && !any_hit) |=> (!pci && !pme)); // R10
  AST_PME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pme && !cmd.pci_w1c) |=> pme); // R9
  AST_PME_NEEDS_PCI: assert property (@(posedge clk) disable iff (!rst_n)
    pme |-> pci); // R9

endmodule

// File: rtl/usb_port_wake_ctl.sv
module usb_port_wake_ctl
  import pws_pkg::*;
#(
  parameter int DATA_W = PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_resume_k,
  input  logic              ev_connect,
  input  logic              ev_disconnect,
  input  logic              ev_overcurrent,
  input  logic              ctl_halted,
  input  logic              sw_wr_en,
  input  logic [SEL_W-1:0]  sw_wr_sel,
  input  logic [DATA_W-1:0] sw_wr_data,
  output logic              port_connected,
  output logic              port_enabled,
  output logic              port_suspended,
  output logic              port_force_resume,
  output logic              port_conn_change,
  output logic              port_oc_active,
  output logic              port_oc_change,
  output logic              port_resuspend,
  output logic              port_change_sts,
  output logic              irq_req,
  output logic              pme_req
);

  pws_pcmd_t pcmd;
  pws_ncmd_t ncmd;
  pws_hit_t  hit;

  pws_sw_decode #(.DATA_W(DATA_W)) u_dec (
    .wr_en   (sw_wr_en),
    .wr_sel  (sw_wr_sel),
    .wr_data (sw_wr_data),
    .pcmd    (pcmd),
    .ncmd    (ncmd)
  );

  pws_port_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_resume (ev_resume_k),
    .ev_conn   (ev_connect),
    .ev_disc   (ev_disconnect),
    .ev_oc     (ev_overcurrent),
    .halted    (ctl_halted),
    .cmd       (pcmd),
    .conn      (port_connected),
    .en        (port_enabled),
    .susp      (port_suspended),
    .fpr       (port_force_resume),
    .csc       (port_conn_change),
    .oca       (port_oc_active),
    .occ       (port_oc_change),
    .resusp    (port_resuspend),
    .hit       (hit)
  );

  pws_notify u_note (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit),
    .cmd   (ncmd),
    .pci   (port_change_sts),
    .irq   (irq_req),
    .pme   (pme_req)
  );

endmodule

// File: tb/sim_usb_port_wake_ctl.sv
`timescale 1ns/1ps
module sim_usb_port_wake_ctl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_resume_k = 0, ev_connect = 0, ev_disconnect = 0, ev_overcurrent = 0;
  logic ctl_halted = 0;
  logic sw_wr_en = 0;
  logic [1:0] sw_wr_sel = '0;
  logic [4:0] sw_wr_data = '0;
  logic port_connected, port_enabled, port_suspended, port_force_resume;
  logic port_conn_change, port_oc_active, port_oc_change, port_resuspend;
  logic port_change_sts, irq_req, pme_req;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  usb_port_wake_ctl u0 (.*);

  task automatic check(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // one clock of stimulus: events {resume, connect, disconnect, overcurrent} plus optional write
  task automatic step(input logic [3:0] ev, input logic w, input logic [1:0] sel, input logic [4:0] d);
    {ev_resume_k, ev_connect, ev_disconnect, ev_overcurrent} = ev;
    sw_wr_en = w; sw_wr_sel = sel; sw_wr_data = d;
    @(negedge clk);
    {ev_resume_k, ev_connect, ev_disconnect, ev_overcurrent} = '0;
    sw_wr_en = 0; sw_wr_sel = '0; sw_wr_data = '0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [4:0] d);
    step(4'b0000, 1'b1, sel, d);
  endtask

  task automatic ev(input logic [3:0] e);
    step(e, 1'b0, 2'd0, 5'd0);
  endtask

  task automatic do_reset();
    ctl_halted = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic setup_suspended();
    do_reset();
    ev(4'b0100);
    wr(2'd0, 5'b00001);
    wr(2'd0, 5'b00011);
    wr(2'd3, 5'b00001);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "connected", port_connected, 0);
    check("R1", "enabled", port_enabled, 0);
    check("R1", "suspended", port_suspended, 0);
    check("R1", "force_resume", port_force_resume, 0);
    check("R1", "change_sts", port_change_sts, 0);
    check("R1", "oc_active", port_oc_active, 0);
    check("R1", "irq", irq_req, 0);
    check("R1", "pme", pme_req, 0);
  endtask

  task automatic t_connect();
    do_reset();
    ev(4'b0100);
    check("R6", "connected", port_connected, 1);
    check("R6", "conn_change", port_conn_change, 1);
    check("R6", "change_sts", port_change_sts, 1);
    check("R9", "pme gated off", pme_req, 0);
    wr(2'd3, 5'b00001);
    wr(2'd0, 5'b01000);
    ev(4'b0100);
    check("R6", "repeat connect sts", port_change_sts, 0);
    check("R6", "repeat connect csc", port_conn_change, 0);
  endtask

  task automatic t_enable();
    do_reset();
    wr(2'd0, 5'b00001);
    check("R13", "enable unconnected", port_enabled, 0);
    ev(4'b0100);
    wr(2'd0, 5'b00010);
    check("R13", "suspend before enable", port_suspended, 0);
    wr(2'd0, 5'b00001);
    check("R13", "enable connected", port_enabled, 1);
    wr(2'd0, 5'b00011);
    check("R13", "suspend set", port_suspended, 1);
    wr(2'd0, 5'b00000);
    check("R13", "enable cleared", port_enabled, 0);
    check("R13", "suspend follows", port_suspended, 0);
  endtask

  task automatic t_resume();
    setup_suspended();
    ev(4'b1000);
    check("R2", "force_resume", port_force_resume, 1);
    check("R2", "change_sts", port_change_sts, 1);
    check("R2", "pme", pme_req, 1);
    check("R2", "still suspended", port_suspended, 1);
    wr(2'd0, 5'b00001);
    check("R3", "fpr cleared", port_force_resume, 0);
    check("R3", "susp cleared", port_suspended, 0);
    check("R3", "enabled", port_enabled, 1);
    wr(2'd3, 5'b00001);
    ev(4'b1000);
    check("R2", "resume not suspended sts", port_change_sts, 0);
    check("R2", "resume not suspended fpr", port_force_resume, 0);
  endtask

  task automatic t_resuspend();
    setup_suspended();
    ev(4'b1000);
    ctl_halted = 1;
    wr(2'd0, 5'b00001);
    check("R4", "fpr cleared", port_force_resume, 0);
    check("R4", "stays suspended", port_suspended, 1);
    check("R4", "resuspend flag", port_resuspend, 1);
    ctl_halted = 0;
    ev(4'b1000);
    check("R4", "resuspend cleared", port_resuspend, 0);
    check("R4", "fpr again", port_force_resume, 1);
  endtask

  task automatic t_disconnect();
    setup_suspended();
    wr(2'd1, 5'b00010);
    ev(4'b0010);
    check("R5", "connected", port_connected, 0);
    check("R5", "enabled", port_enabled, 0);
    check("R5", "suspended", port_suspended, 0);
    check("R5", "conn_change", port_conn_change, 1);
    check("R9", "pme disc enabled", pme_req, 1);
    wr(2'd3, 5'b00000);
    check("R10", "ack zero ignored", port_change_sts, 1);
    wr(2'd3, 5'b00001);
    check("R10", "ack clears sts", port_change_sts, 0);
    check("R10", "ack clears pme", pme_req, 0);
    ev(4'b0010);
    check("R5", "disc unconnected", port_change_sts, 0);
  endtask

  task automatic t_overcurrent();
    do_reset();
    ev(4'b0100);
    wr(2'd0, 5'b00001);
    wr(2'd3, 5'b00001);
    ev(4'b0001);
    check("R7", "oc_active", port_oc_active, 1);
    check("R7", "oc_change", port_oc_change, 1);
    check("R7", "enable cleared", port_enabled, 0);
    check("R7", "change_sts", port_change_sts, 1);
    check("R9", "pme oc gated off", pme_req, 0);
    wr(2'd0, 5'b00001);
    check("R13", "enable blocked by oc", port_enabled, 0);
    check("R11", "occ zero ignored", port_oc_change, 1);
    check("R11", "csc zero ignored", port_conn_change, 1);
    wr(2'd0, 5'b10000);
    check("R11", "occ w1c", port_oc_change, 0);
    wr(2'd0, 5'b01000);
    check("R11", "csc w1c", port_conn_change, 0);
  endtask

  task automatic t_wake_oc();
    do_reset();
    wr(2'd1, 5'b00100);
    ev(4'b0100);
    check("R9", "connect with only oc wake", pme_req, 0);
    ev(4'b0001);
    check("R9", "oc wake", pme_req, 1);
    ev(4'b0010);
    check("R9", "pme holds", pme_req, 1);
  endtask

  task automatic t_irq();
    do_reset();
    ev(4'b0100);
    check("R8", "irq disabled", irq_req, 0);
    wr(2'd2, 5'b00001);
    check("R8", "irq enabled", irq_req, 1);
    wr(2'd3, 5'b00001);
    check("R8", "irq after ack", irq_req, 0);
  endtask

  task automatic t_collide();
    do_reset();
    wr(2'd1, 5'b00001);
    step(4'b0100, 1'b1, 2'd3, 5'b00001);
    check("R12", "sts set wins", port_change_sts, 1);
    check("R12", "pme set wins", pme_req, 1);
    step(4'b0010, 1'b1, 2'd0, 5'b01000);
    check("R12", "csc set wins", port_conn_change, 1);
    ev(4'b0100);
    step(4'b0001, 1'b1, 2'd0, 5'b10000);
    check("R12", "occ set wins", port_oc_change, 1);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    total++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_connect();
    t_enable();
    t_resume();
    t_resuspend();
    t_disconnect();
    t_overcurrent();
    t_wake_oc();
    t_irq();
    t_collide();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule